// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block turns the bus writes aimed at a parallel NOR-style flash model into read-mode changes and one-cycle requests for the execution engine that runs programs, erases and the other internal operations. Each rising edge of the write strobe carries one address and one data word. The block follows the two-write unlock prefix. For erase and lock it also follows the set-up code and the second unlock pair. It then decodes the command byte from the low eight data bits.

The engine reports back through six plain flags: busy, busy with an erase, erase suspended, program failed, erase failed, and asleep. From these flags the decoder picks one acceptance policy per write, so a running erase, a suspended erase, a running program, sleep and a sticky failure each accept only a narrow set of commands.

The write side has no back-pressure. Every strobe edge is consumed on the clock edge that sees it, so there is no ready signal. The request outputs form a one-hot pulse vector, and `cmd_addr` holds the address of the write that raised the latest request.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While `rst_n` is low and right after it, `read_mode` is 0 (array), `eng_req` is all zero and `cmd_addr` is zero. Any partial sequence is dropped.
- R2: A write is taken once per low-to-high transition of `wr_valid`, however long the level stays high. A request appears on `eng_req` in the cycle after that edge and lasts exactly one cycle.
- R3: The unlock prefix is 0xAA at 0x5555 followed by 0x55 at 0x2AAA. Only address bits 14:0 and data bits 7:0 are compared. Any number of idle cycles may pass between the writes of a sequence.
- R4: `read_mode` encodes 0 array, 1 silicon ID, 2 status, 3 page buffer. After the prefix, a write at 0x5555 of 0x90 selects 1, 0x70 selects 2 and 0x75 selects 3. A single 0xF0 write at any address selects 0.
- R5: `eng_req` bits: 0 program, 1 buffer write, 2 buffer clear, 3 chip erase, 4 block erase, 5 lock, 6 sleep, 7 suspend, 8 resume, 9 status clear. After the prefix, a write at 0x5555 maps codes to bits as follows: 0xA0 to bit 0 (mode becomes status), 0xE0 to bit 1, 0x04 to bit 2, 0x50 to bit 9, and 0xC0 to bit 6 (mode becomes status).
- R6: Prefix, then 0x80 at 0x5555, then the prefix again, then a final write. The final write of 0x10 at 0x5555 raises bit 3. The final write of 0x30 at any address raises bit 4. The final write of 0x20 at any address raises bit 5. Each of these sets mode to status and loads `cmd_addr` with that write's address.
- R7: With no flag set, a wrong data value or wrong address in a sequence drops it, raises no request and sets mode to array.
- R8: With no erase running or suspended, single writes of 0xB0 or 0x30 raise nothing and leave the mode unchanged.
- R9: While busy with an erase (not suspended), only a single 0xB0 write is accepted. It raises bit 7 and sets mode to status. Every other write leaves the mode and requests untouched.
- R10: While suspended, only 0xF0, a single 0x30 (raises bit 8) and the status read are accepted. Buffer read, sleep and 0xB0 are ignored.
- R11: While a fail flag is set (engine idle), only status clear, status read and 0xF0 are accepted.
- R12: While busy with a program, only status read and sleep are accepted. 0xF0 is ignored.
- R13: While asleep (engine idle), only 0xF0 and the silicon ID read are accepted.
- R14: A write that the current policy refuses drops any partial sequence, raises nothing and leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write strobe; its rising edge carries one write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; bits 7:0 decoded |
| eng_busy | input | 1 | Engine running an operation |
| eng_erasing | input | 1 | Running operation is an erase |
| eng_suspended | input | 1 | Erase suspended |
| pgm_fail | input | 1 | Sticky program failure |
| ers_fail | input | 1 | Sticky erase failure |
| eng_sleeping | input | 1 | Engine in sleep |
| read_mode | output | 2 | Read source select |
| eng_req | output | NUM_REQ | One-cycle one-hot request pulses |
| cmd_addr | output | ADDR_W | Address of the latest request |

## Verification
The properties assume that the engine flags change only between writes and stay constant through the cycle in which a strobe edge is taken. They also assume `wr_valid` is low while reset is held, so the first write after reset is a genuine rising edge. The stimulus changes every input on the falling clock edge. It lowers the strobe for at least one cycle between writes and sets the flag pattern of each scenario before that scenario's first write.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int NUM_REQ = 10;
  localparam int RQ_PROG   = 0;
  localparam int RQ_BUFW   = 1;
  localparam int RQ_BUFCLR = 2;
  localparam int RQ_CHIP   = 3;
  localparam int RQ_BLOCK  = 4;
  localparam int RQ_LOCK   = 5;
  localparam int RQ_SLEEP  = 6;
  localparam int RQ_SUSP   = 7;
  localparam int RQ_RESUME = 8;
  localparam int RQ_STCLR  = 9;

  localparam logic [14:0] KEY_ADDR1 = 15'h5555;
  localparam logic [14:0] KEY_ADDR2 = 15'h2AAA;

  localparam logic [7:0] OP_KEY1    = 8'hAA;
  localparam logic [7:0] OP_KEY2    = 8'h55;
  localparam logic [7:0] OP_ARRAY   = 8'hF0;
  localparam logic [7:0] OP_ID      = 8'h90;
  localparam logic [7:0] OP_PROG    = 8'hA0;
  localparam logic [7:0] OP_BUFW    = 8'hE0;
  localparam logic [7:0] OP_BUFR    = 8'h75;
  localparam logic [7:0] OP_STAT    = 8'h70;
  localparam logic [7:0] OP_STCLR   = 8'h50;
  localparam logic [7:0] OP_BUFCLR  = 8'h04;
  localparam logic [7:0] OP_SLEEP   = 8'hC0;
  localparam logic [7:0] OP_SETUP   = 8'h80;
  localparam logic [7:0] OP_CHIP    = 8'h10;
  localparam logic [7:0] OP_BLOCK   = 8'h30;
  localparam logic [7:0] OP_LOCK    = 8'h20;
  localparam logic [7:0] OP_SUSP    = 8'hB0;
  localparam logic [7:0] OP_RESUME  = 8'h30;

  typedef enum logic [1:0] {
    RM_ARRAY = 2'd0, RM_ID = 2'd1, RM_STATUS = 2'd2, RM_BUF = 2'd3
  } rmode_t;

  typedef enum logic [2:0] {
    CT_NORMAL, CT_ERASING, CT_SUSP, CT_PROG, CT_SLEEP, CT_ERROR
  } cat_t;

  typedef enum logic [4:0] {
    EV_NONE, EV_BAD, EV_RESET, EV_SUSP, EV_RESUME, EV_ID, EV_PROG,
    EV_BUFW, EV_BUFR, EV_STAT, EV_STCLR, EV_BUFCLR, EV_SLEEP, EV_SETUP,
    EV_CHIP, EV_BLOCK, EV_LOCK
  } ev_t;
endpackage

// File: rtl/fcd_strobe.sv
module fcd_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  output logic take
);
  logic valid_q;
  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= 1'b1;
    else        valid_q <= valid;
  end
  assign take = valid & ~valid_q;
endmodule

// File: rtl/fcd_policy.sv
module fcd_policy
  import flash_cmd_pkg::*;
(
  input  logic busy,
  input  logic erasing,
  input  logic suspended,
  input  logic fail,
  input  logic sleeping,
  input  ev_t  evt,
  output cat_t cat,
  output logic ok
);
  always_comb begin
    if (suspended)              cat = CT_SUSP;
    else if (busy && erasing)   cat = CT_ERASING;
    else if (busy)              cat = CT_PROG;
    else if (sleeping)          cat = CT_SLEEP;
    else if (fail)              cat = CT_ERROR;
    else                        cat = CT_NORMAL;
  end

  always_comb begin
    ok = 1'b0;
    unique case (cat)
      CT_NORMAL:  ok = !(evt inside {EV_NONE, EV_BAD, EV_SUSP, EV_RESUME});
      CT_ERASING: ok = (evt == EV_SUSP);
      CT_SUSP:    ok = (evt inside {EV_RESET, EV_RESUME, EV_STAT});
      CT_PROG:    ok = (evt inside {EV_STAT, EV_SLEEP});
      CT_SLEEP:   ok = (evt inside {EV_RESET, EV_ID});
      CT_ERROR:   ok = (evt inside {EV_RESET, EV_STAT, EV_STCLR});
      default:    ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import flash_cmd_pkg::*;
#(
  parameter int MATCH_W = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [MATCH_W-1:0] addr_lo,
  input  logic [7:0]         code,
  input  logic               ok,
  output ev_t                evt
);
  typedef enum logic [2:0] {SQ_IDLE, SQ_U1, SQ_CMD, SQ_SET, SQ_SU1, SQ_FIN} sq_t;
  sq_t state, adv;
  logic at_k1, at_k2;

  assign at_k1 = (addr_lo == MATCH_W'(KEY_ADDR1));
  assign at_k2 = (addr_lo == MATCH_W'(KEY_ADDR2));

  always_comb begin
    evt = EV_NONE;
    adv = state;
    if (take) begin
      unique case (state)
        SQ_IDLE: begin
          if (code == OP_KEY1 && at_k1) adv = SQ_U1;
          else if (code == OP_ARRAY)    evt = EV_RESET;
          else if (code == OP_SUSP)     evt = EV_SUSP;
          else if (code == OP_RESUME)   evt = EV_RESUME;
          else                          evt = EV_BAD;
        end
        SQ_U1:  if (code == OP_KEY2 && at_k2) adv = SQ_CMD; else evt = EV_BAD;
        SQ_CMD: begin
          if (!at_k1) evt = EV_BAD;
          else begin
            unique case (code)
              OP_ID:     evt = EV_ID;
              OP_PROG:   evt = EV_PROG;
              OP_BUFW:   evt = EV_BUFW;
              OP_BUFR:   evt = EV_BUFR;
              OP_STAT:   evt = EV_STAT;
              OP_STCLR:  evt = EV_STCLR;
              OP_BUFCLR: evt = EV_BUFCLR;
              OP_SLEEP:  evt = EV_SLEEP;
              OP_SETUP:  evt = EV_SETUP;
              default:   evt = EV_BAD;
            endcase
          end
        end
        SQ_SET: if (code == OP_KEY1 && at_k1) adv = SQ_SU1; else evt = EV_BAD;
        SQ_SU1: if (code == OP_KEY2 && at_k2) adv = SQ_FIN; else evt = EV_BAD;
        SQ_FIN: begin
          if (code == OP_CHIP && at_k1)  evt = EV_CHIP;
          else if (code == OP_BLOCK)     evt = EV_BLOCK;
          else if (code == OP_LOCK)      evt = EV_LOCK;
          else                           evt = EV_BAD;
        end
        default: evt = EV_BAD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= SQ_IDLE;
    else if (take) begin
      if (evt == EV_NONE)              state <= adv;
      else if (evt == EV_SETUP && ok)  state <= SQ_SET;
      else                             state <= SQ_IDLE;
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int MATCH_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              eng_busy,
  input  logic              eng_erasing,
  input  logic              eng_suspended,
  input  logic              pgm_fail,
  input  logic              ers_fail,
  input  logic              eng_sleeping,
  output logic [1:0]        read_mode,
  output logic [NUM_REQ-1:0] eng_req,
  output logic [ADDR_W-1:0] cmd_addr
);
  logic take, ok;
  ev_t  evt;
  cat_t cat;
  rmode_t mode_q;

  fcd_strobe u_strobe (.clk(clk), .rst_n(rst_n), .valid(wr_valid), .take(take));

  fcd_seq #(.MATCH_W(MATCH_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .take(take), .addr_lo(wr_addr[MATCH_W-1:0]),
    .code(wr_data[7:0]), .ok(ok), .evt(evt)
  );

  fcd_policy u_policy (
    .busy(eng_busy), .erasing(eng_erasing), .suspended(eng_suspended),
    .fail(pgm_fail | ers_fail), .sleeping(eng_sleeping),
    .evt(evt), .cat(cat), .ok(ok)
  );

  logic [NUM_REQ-1:0] req_d;
  always_comb begin
    req_d = '0;
    if (ok) begin
      unique case (evt)
        EV_PROG:   req_d[RQ_PROG]   = 1'b1;
        EV_BUFW:   req_d[RQ_BUFW]   = 1'b1;
        EV_BUFCLR: req_d[RQ_BUFCLR] = 1'b1;
        EV_CHIP:   req_d[RQ_CHIP]   = 1'b1;
        EV_BLOCK:  req_d[RQ_BLOCK]  = 1'b1;
        EV_LOCK:   req_d[RQ_LOCK]   = 1'b1;
        EV_SLEEP:  req_d[RQ_SLEEP]  = 1'b1;
        EV_SUSP:   req_d[RQ_SUSP]   = 1'b1;
        EV_RESUME: req_d[RQ_RESUME] = 1'b1;
        EV_STCLR:  req_d[RQ_STCLR]  = 1'b1;
        default:   req_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= RM_ARRAY;
      eng_req  <= '0;
      cmd_addr <= '0;
    end else begin
      eng_req <= req_d;
      if (|req_d) cmd_addr <= wr_addr;
      if (ok) begin
        unique case (evt)
          EV_RESET: mode_q <= RM_ARRAY;
          EV_ID:    mode_q <= RM_ID;
          EV_STAT:  mode_q <= RM_STATUS;
          EV_BUFR:  mode_q <= RM_BUF;
          EV_PROG, EV_SLEEP, EV_CHIP, EV_BLOCK, EV_LOCK, EV_SUSP:
                    mode_q <= RM_STATUS;
          default:  mode_q <= mode_q;
        endcase
      end else if (evt == EV_BAD && cat == CT_NORMAL) begin
        mode_q <= RM_ARRAY;
      end
    end
  end

  assign read_mode = mode_q;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              eng_busy,
  input logic              eng_erasing,
  input logic              eng_suspended,
  input logic              pgm_fail,
  input logic              ers_fail,
  input logic              eng_sleeping,
  input logic [1:0]        read_mode,
  input logic [NUM_REQ-1:0] eng_req,
  input logic [ADDR_W-1:0] cmd_addr
);
  localparam logic [NUM_REQ-1:0] M_SUSP   = NUM_REQ'(1) << RQ_SUSP;
  localparam logic [NUM_REQ-1:0] M_RESUME = NUM_REQ'(1) << RQ_RESUME;
  localparam logic [NUM_REQ-1:0] M_STCLR  = NUM_REQ'(1) << RQ_STCLR;
  localparam logic [NUM_REQ-1:0] M_SLEEP  = NUM_REQ'(1) << RQ_SLEEP;

  assert_req_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_req));

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (read_mode == 2'd0 && eng_req == '0));

  assert_req_after_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req != '0) |-> ($past(wr_valid) && !$past(wr_valid, 2)));

  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(wr_valid) && !$past(wr_valid, 2)) |-> $stable(read_mode));

  assert_erase_only_suspend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(eng_busy && eng_erasing && !eng_suspended)) |-> ((eng_req & ~M_SUSP) == '0));

  assert_suspended_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(eng_suspended) |->
      (((eng_req & ~M_RESUME) == '0) && !(read_mode == 2'd3 && $past(read_mode) != 2'd3)));

  assert_fail_lockout_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past((pgm_fail || ers_fail) && !eng_busy && !eng_suspended && !eng_sleeping)
      |-> ((eng_req & ~M_STCLR) == '0));

  assert_prog_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(eng_busy && !eng_erasing && !eng_suspended) |-> ((eng_req & ~M_SLEEP) == '0));

  assert_sleep_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $past(eng_sleeping && !eng_busy && !eng_suspended) |-> (eng_req == '0));
endmodule

bind flash_cmd_decoder fcd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fcd_checker (.*);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        eng_busy = 0, eng_erasing = 0, eng_suspended = 0;
  logic        pgm_fail = 0, ers_fail = 0, eng_sleeping = 0;
  logic [1:0]  read_mode;
  logic [9:0]  eng_req;
  logic [19:0] cmd_addr;
  logic [9:0]  got_req;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .eng_busy(eng_busy), .eng_erasing(eng_erasing), .eng_suspended(eng_suspended),
    .pgm_fail(pgm_fail), .ers_fail(ers_fail), .eng_sleeping(eng_sleeping),
    .read_mode(read_mode), .eng_req(eng_req), .cmd_addr(cmd_addr)
  );

  localparam logic [9:0] B_PROG = 10'h001, B_BUFW = 10'h002, B_BUFCLR = 10'h004,
    B_CHIP = 10'h008, B_BLOCK = 10'h010, B_LOCK = 10'h020, B_SLEEP = 10'h040,
    B_SUSP = 10'h080, B_RESUME = 10'h100, B_STCLR = 10'h200, NONE = 10'h000;

  task automatic wr(input logic [19:0] a, input logic [15:0] d);
    @(negedge clk); wr_addr = a; wr_data = d; wr_valid = 1'b1;
    @(negedge clk); got_req = eng_req; wr_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic cmd3(input logic [7:0] c);
    wr(20'h05555, 16'h00AA); wr(20'h02AAA, 16'h0055); wr(20'h05555, {8'h00, c});
  endtask

  task automatic erase6(input logic [19:0] a, input logic [7:0] c);
    cmd3(8'h80);
    wr(20'h05555, 16'h00AA); wr(20'h02AAA, 16'h0055); wr(a, {8'h00, c});
  endtask

  task automatic chk(input string tag, input logic [1:0] em, input logic [9:0] er);
    checks++;
    if (read_mode !== em || got_req !== er) begin
      fails++;
      $display("FAIL %s: mode=%0d req=%h expected mode=%0d req=%h", tag, read_mode, got_req, em, er);
    end
  endtask

  task automatic flags(input logic b, e, s, pf, sl);
    @(negedge clk);
    eng_busy = b; eng_erasing = e; eng_suspended = s; pgm_fail = pf; eng_sleeping = sl;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    checks++;
    if (read_mode !== 2'd0 || eng_req !== NONE || cmd_addr !== '0) begin
      fails++;
      $display("FAIL R1: mode=%0d req=%h addr=%h expected 0/000/00000", read_mode, eng_req, cmd_addr);
    end
    rst_n = 1'b1;
  endtask

  task automatic t_modes;
    cmd3(8'h90); chk("R4 id", 2'd1, NONE);
    cmd3(8'h70); chk("R4 status", 2'd2, NONE);
    cmd3(8'h75); chk("R4 buffer", 2'd3, NONE);
    wr(20'h7ABCD, 16'h00F0); chk("R4 array", 2'd0, NONE);
    // R3: upper address and data bits ignored, long idle gap mid-sequence
    wr(20'hF5555, 16'hFFAA); repeat (40) @(negedge clk);
    wr(20'hA2AAA, 16'h1255); wr(20'h35555, 16'hEE90); chk("R3 masked unlock", 2'd1, NONE);
  endtask

  task automatic t_requests;
    wr(20'h00000, 16'h00F0);
    cmd3(8'hA0); chk("R5 program", 2'd2, B_PROG);
    checks++;
    if (eng_req !== NONE) begin
      fails++; $display("FAIL R2: req=%h expected 000 one cycle later", eng_req);
    end
    wr(20'h00000, 16'h00F0);
    cmd3(8'hE0); chk("R5 buffer write", 2'd0, B_BUFW);
    cmd3(8'h04); chk("R5 buffer clear", 2'd0, B_BUFCLR);
    cmd3(8'h50); chk("R5 status clear", 2'd0, B_STCLR);
    cmd3(8'hC0); chk("R5 sleep", 2'd2, B_SLEEP);
  endtask

  task automatic t_erase;
    wr(20'h00000, 16'h00F0);
    erase6(20'h05555, 8'h10); chk("R6 chip erase", 2'd2, B_CHIP);
    wr(20'h00000, 16'h00F0);
    erase6(20'h42000, 8'h30); chk("R6 block erase", 2'd2, B_BLOCK);
    checks++;
    if (cmd_addr !== 20'h42000) begin
      fails++; $display("FAIL R6: cmd_addr=%h expected 42000", cmd_addr);
    end
    erase6(20'h00100, 8'h20); chk("R6 lock", 2'd2, B_LOCK);
  endtask

  task automatic t_bad;
    cmd3(8'h90);
    wr(20'h05555, 16'h00AA); wr(20'h01234, 16'h0055); chk("R7 bad address", 2'd0, NONE);
    cmd3(8'h90); cmd3(8'h91); chk("R7 bad code", 2'd0, NONE);
    cmd3(8'h90);
    wr(20'h00010, 16'h00B0); chk("R8 stray suspend", 2'd1, NONE);
    wr(20'h00010, 16'h0030); chk("R8 stray resume", 2'd1, NONE);
  endtask

  task automatic t_strobe;
    wr(20'h00000, 16'h00F0);
    @(negedge clk); wr_addr = 20'h05555; wr_data = 16'h00AA; wr_valid = 1'b1;
    repeat (4) @(negedge clk);
    wr_valid = 1'b0; @(negedge clk);
    wr(20'h02AAA, 16'h0055); wr(20'h05555, 16'h0070); chk("R2 held strobe once", 2'd2, NONE);
  endtask

  task automatic t_erasing;
    cmd3(8'h90);
    flags(1, 1, 0, 0, 0);
    wr(20'h00000, 16'h00F0); chk("R9 array refused", 2'd1, NONE);
    cmd3(8'h70); chk("R9 status refused", 2'd1, NONE);
    wr(20'h00000, 16'h0030); chk("R9 resume no effect", 2'd1, NONE);
    wr(20'h00000, 16'h00B0); chk("R9 suspend", 2'd2, B_SUSP);
  endtask

  task automatic t_suspended;
    flags(0, 1, 1, 0, 0);
    cmd3(8'h75); chk("R10 buffer read refused", 2'd2, NONE);
    cmd3(8'hC0); chk("R10 sleep ignored", 2'd2, NONE);
    wr(20'h00000, 16'h00B0); chk("R10 second suspend ignored", 2'd2, NONE);
    wr(20'h00000, 16'h00F0); chk("R10 array", 2'd0, NONE);
    cmd3(8'h70); chk("R10 status", 2'd2, NONE);
    wr(20'h00000, 16'h0030); chk("R10 resume", 2'd2, B_RESUME);
    flags(0, 0, 0, 0, 0);
  endtask

  task automatic t_error;
    wr(20'h00000, 16'h00F0);
    flags(0, 0, 0, 1, 0);
    cmd3(8'hA0); chk("R11 program refused", 2'd0, NONE);
    cmd3(8'h90); chk("R14 id refused", 2'd0, NONE);
    cmd3(8'h70); chk("R11 status", 2'd2, NONE);
    wr(20'h00000, 16'h00F0); chk("R11 array", 2'd0, NONE);
    cmd3(8'h50); chk("R11 status clear", 2'd0, B_STCLR);
    flags(0, 0, 0, 0, 0);
  endtask

  task automatic t_prog_busy;
    cmd3(8'h90);
    flags(1, 0, 0, 0, 0);
    wr(20'h00000, 16'h00F0); chk("R12 array refused", 2'd1, NONE);
    cmd3(8'h70); chk("R12 status", 2'd2, NONE);
    cmd3(8'hC0); chk("R12 sleep", 2'd2, B_SLEEP);
    flags(0, 0, 0, 0, 0);
  endtask

  task automatic t_sleep;
    wr(20'h00000, 16'h00F0);
    flags(0, 0, 0, 0, 1);
    cmd3(8'h70); chk("R13 status refused", 2'd0, NONE);
    cmd3(8'hA0); chk("R13 program refused", 2'd0, NONE);
    cmd3(8'h90); chk("R13 id", 2'd1, NONE);
    wr(20'h00000, 16'h00F0); chk("R13 wake array", 2'd0, NONE);
    flags(0, 0, 0, 0, 0);
  endtask

  initial begin
    t_reset;
    t_modes;
    t_requests;
    t_erase;
    t_bad;
    t_strobe;
    t_erasing;
    t_suspended;
    t_error;
    t_prog_busy;
    t_sleep;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule